// File: doc/BRIEF.md
# Converter calibration and power-down sequencer

This block sequences the power states of a stereo audio converter's digital side. A power-down level input parks the converter. When it is released, the block issues a one-cycle reference-initialize pulse and a one-cycle divider-realignment pulse. A rising edge on the asynchronous calibration request starts a calibration that lasts a fixed number of frame periods. While calibration runs, the block holds the data path and forces the serial data stream to zero.

When calibration completes, the block emits the divider-realignment pulse, which resets the bit-clock and frame-clock dividers. Every device that shares the master clock and sees the request rise before the same master-clock edge then resumes sampling on one common edge. The request passes through a two-flop synchronizer, so the latency from request to action is a fixed number of master-clock cycles. The frame tick is a one-cycle, master-clock-synchronous pulse, one per frame. The power-down input is taken as synchronous to the master clock.

Top module: `cal_pwr_seq`

## Requirements
- R1: During and directly after reset, pd_en, ref_init, calibrating and div_sync are all 0.
- R2: A low-to-high change of cal_req is resynchronized by two flops. calibrating rises at the third rising clk edge that samples cal_req high, which fixes the latency for every device sharing clk. A steady high level starts nothing further.
- R3: Calibration counts frame_tick pulses sampled at edges where calibrating is already 1. It ends (calibrating falls) at the edge that samples the CAL_FRAMES-th such pulse. The default for CAL_FRAMES is 4100.
- R4: At the edge where calibration completes, div_sync pulses high for exactly one cycle to realign the clock dividers.
- R5: A new detected rising edge of the request during calibration restarts the count from zero, and it takes priority over a frame_tick in the same cycle.
- R6: pd_en follows pwr_down_req one clk edge later. The edge that raises pd_en also aborts any calibration at once, with no div_sync.
- R7: A detected request edge is ignored while pwr_down_req or pd_en is 1, and it does not start a calibration after power-down ends.
- R8: At the edge where pd_en falls, ref_init and div_sync are each 1 for exactly one cycle.
- R9: sdata_out is 0 while calibrating or pd_en is 1. Otherwise it equals sdata_in, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down_req | input | 1 | Power-down level, synchronous to clk |
| cal_req | input | 1 | Asynchronous calibration request, acts on its rising edge |
| frame_tick | input | 1 | One-cycle pulse per frame period |
| sdata_in | input | 1 | Serial data from the data path |
| pd_en | output | 1 | Power-down enable |
| ref_init | output | 1 | Reference-initialize pulse |
| calibrating | output | 1 | Calibration in progress, holds the data path |
| div_sync | output | 1 | Clock-divider realignment pulse |
| sdata_out | output | 1 | Serial data, zeroed while muted |

## Verification
Directed sequences pin down the resynchronizer latency and the exact tick on which calibration ends. A second rising edge partway through a calibration separates a restart from a continued count. A request raised inside power-down and held through its release separates an ignored edge from one left pending. A long seeded random phase mixes sparse power-down periods, request toggles and irregular frame ticks, including coincident restart and tick cycles, and compares every output each cycle with a bench model.

// File: rtl/cal_pwr_seq.sv
module cal_pwr_seq #(
  parameter int CAL_FRAMES = 4100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down_req,
  input  logic cal_req,
  input  logic frame_tick,
  input  logic sdata_in,
  output logic pd_en,
  output logic ref_init,
  output logic calibrating,
  output logic div_sync,
  output logic sdata_out
);
  localparam int CW = $clog2(CAL_FRAMES + 1);
  localparam logic [CW-1:0] LAST = CW'(CAL_FRAMES - 1);

  logic [2:0]    req_sh;
  logic [CW-1:0] cnt;

  wire req_rise = req_sh[1] & ~req_sh[2];
  wire pd_exit  = pd_en & ~pwr_down_req;
  wire cal_done = calibrating & frame_tick & (cnt == LAST) & ~req_rise & ~pwr_down_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_sh      <= '0;
      pd_en       <= 1'b0;
      ref_init    <= 1'b0;
      div_sync    <= 1'b0;
      calibrating <= 1'b0;
      cnt         <= '0;
    end else begin
      req_sh   <= {req_sh[1:0], cal_req};
      pd_en    <= pwr_down_req;
      ref_init <= pd_exit;
      div_sync <= pd_exit | cal_done;
      if (pwr_down_req) begin
        calibrating <= 1'b0;
        cnt         <= '0;
      end else if (req_rise && !pd_en) begin
        calibrating <= 1'b1;
        cnt         <= '0;
      end else if (calibrating && frame_tick) begin
        if (cnt == LAST) begin
          calibrating <= 1'b0;
          cnt         <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign sdata_out = sdata_in & ~calibrating & ~pd_en;

  a_r6_pd_blocks_cal: assert property (@(posedge clk) disable iff (!rst_n)
    pd_en |-> !calibrating);
  a_r8_init_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ref_init |-> ($past(pd_en) && !pd_en));
  a_r8_init_with_sync: assert property (@(posedge clk) disable iff (!rst_n)
    ref_init |-> div_sync);
  a_r4_end_sync: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(calibrating) && !pd_en) |-> div_sync);
  a_r4_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    div_sync |=> !div_sync);
  a_r2_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(calibrating) |-> (!pd_en && cnt == '0));
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: tb/cal_pwr_seq_test.sv
module cal_pwr_seq_test;
  localparam int N = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_down_req = 0, cal_req = 0, frame_tick = 0, sdata_in = 0;
  logic pd_en, ref_init, calibrating, div_sync, sdata_out;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  cal_pwr_seq #(.CAL_FRAMES(N)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_down_req(pwr_down_req), .cal_req(cal_req),
    .frame_tick(frame_tick), .sdata_in(sdata_in), .pd_en(pd_en), .ref_init(ref_init),
    .calibrating(calibrating), .div_sync(div_sync), .sdata_out(sdata_out));

  // bench model built from the requirements
  logic h1, h2, h3, m_pd, m_cal, m_ri, m_ds;
  int m_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      h1 <= 0; h2 <= 0; h3 <= 0; m_pd <= 0; m_cal <= 0; m_ri <= 0; m_ds <= 0; m_cnt <= 0;
    end else begin
      logic rise, ex, fin;
      rise = h2 && !h3;
      ex = m_pd && !pwr_down_req;
      fin = 0;
      h1 <= cal_req; h2 <= h1; h3 <= h2;
      m_pd <= pwr_down_req;
      if (pwr_down_req) m_cal <= 0;
      else if (rise && !m_pd) begin m_cal <= 1; m_cnt <= 0; end
      else if (m_cal && frame_tick) begin
        if (m_cnt + 1 == N) begin m_cal <= 0; fin = 1; end
        else m_cnt <= m_cnt + 1;
      end
      m_ri <= ex;
      m_ds <= ex | fin;
    end
  end

  function automatic logic exp_sdata(logic c, logic p, logic d);
    return d && !c && !p;
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic cmp_model();
    chk("R6", "pd_en", pd_en, m_pd);
    chk("R3", "calibrating", calibrating, m_cal);
    chk("R4", "div_sync", div_sync, m_ds);
    chk("R8", "ref_init", ref_init, m_ri);
    chk("R9", "sdata_out", sdata_out, exp_sdata(m_cal, m_pd, sdata_in));
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      frame_tick = 1; step(); frame_tick = 0; step();
    end
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) step();
    chk("R1", "pd_en", pd_en, 0); chk("R1", "ref_init", ref_init, 0);
    chk("R1", "calibrating", calibrating, 0); chk("R1", "div_sync", div_sync, 0);
    rst_n = 1; step();
    chk("R1", "calibrating after reset", calibrating, 0);

    // R2 latency
    cal_req = 1; step();
    chk("R2", "cal after 1 edge", calibrating, 0); step();
    chk("R2", "cal after 2 edges", calibrating, 0); step();
    chk("R2", "cal after 3 edges", calibrating, 1);
    sdata_in = 1; #0.1;
    chk("R9", "muted in cal", sdata_out, 0);

    // R3 / R4 length and end pulse
    ticks(N - 1);
    chk("R3", "still calibrating before last tick", calibrating, 1);
    frame_tick = 1; step(); frame_tick = 0;
    chk("R3", "ended on last tick", calibrating, 0);
    chk("R4", "div_sync at end", div_sync, 1);
    chk("R9", "data passes", sdata_out, 1);
    step();
    chk("R4", "div_sync one cycle", div_sync, 0);
    repeat (4) step();
    chk("R2", "held level starts nothing", calibrating, 0);

    // R5 restart
    cal_req = 0; repeat (3) step();
    cal_req = 1; repeat (3) step();
    chk("R5", "second cal started", calibrating, 1);
    ticks(5);
    cal_req = 0; repeat (3) step();
    cal_req = 1; step(); step();
    frame_tick = 1; step(); frame_tick = 0;
    chk("R5", "restart cycle", calibrating, 1);
    ticks(N - 1);
    chk("R5", "count restarted", calibrating, 1);
    ticks(1);
    chk("R5", "restarted count ends", calibrating, 0);

    // R6 / R7 / R8 power-down
    cal_req = 0; repeat (3) step();
    cal_req = 1; repeat (3) step();
    chk("R6", "cal before pd", calibrating, 1);
    pwr_down_req = 1; step();
    chk("R6", "pd_en high", pd_en, 1);
    chk("R6", "cal aborted", calibrating, 0);
    chk("R6", "no sync on abort", div_sync, 0);
    chk("R9", "muted in pd", sdata_out, 0);
    cal_req = 0; repeat (3) step();
    cal_req = 1; repeat (5) step();
    chk("R7", "req ignored in pd", calibrating, 0);
    pwr_down_req = 0; step();
    chk("R8", "pd_en low", pd_en, 0);
    chk("R8", "ref_init pulse", ref_init, 1);
    chk("R8", "div_sync pulse", div_sync, 1);
    step();
    chk("R8", "ref_init one cycle", ref_init, 0);
    chk("R8", "div_sync one cycle", div_sync, 0);
    repeat (3) step();
    chk("R7", "no pending cal", calibrating, 0);

    // random phase against model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 999);
      if (r < 6) pwr_down_req = ~pwr_down_req;
      if ($urandom_range(0, 99) < 3) cal_req = ~cal_req;
      frame_tick = ($urandom_range(0, 3) == 0);
      sdata_in = $urandom_range(0, 1);
      step();
      cmp_model();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule